// File: doc/BRIEF.md
# RS-485 Multidrop Address Filter and Line Turnaround Control

This block sits next to a UART and handles the two parts of multidrop RS-485 operation. On the receive side it takes 9-bit characters from the deserialiser. The top bit of each character separates address bytes from data bytes. When filtering is switched on, the block passes only the traffic meant for this node. A byte carrying the node's own address selects the node. Data then flows until an address byte for another node arrives. Everything else is dropped before it reaches the receive buffer.

On the transmit side it generates the line-driver enable. The enable is raised as soon as data waits to be sent or the shifter is busy. After the shifter goes quiet, the enable is held for a programmed number of bit periods so the far end sees a clean line release. The enable can be routed to either of two modem-control pins. While automatic direction control is on, it takes over that pin from both the software-written level and the hardware flow-control level.

Top module: `rs485_node_ctl`

## Requirements
- R1: After reset, rx_valid_o is 0 and the node is unselected. With filtering on, a data byte received before any address byte is dropped.
- R2: With filt_en_i low, every character presented with rx_valid_i is forwarded. rx_valid_o pulses one cycle later and rx_data_o carries rx_char_i[7:0].
- R3: With filtering on, a character with rx_char_i[8]=1 whose low byte equals node_addr_i is forwarded, and it selects the node.
- R4: With filtering on, a data byte (rx_char_i[8]=0) arriving while the node is unselected is dropped, so rx_valid_o stays 0.
- R5: With filtering on, an address byte (rx_char_i[8]=1) that differs from node_addr_i is dropped and deselects the node.
- R6: With filtering on, data bytes received while the node is selected are forwarded with their low byte.
- R7: Clearing filt_en_i deselects the node. After filtering is switched back on, data bytes are dropped until a matching address arrives.
- R8: The driver enable is 1 in the same cycle in which tx_pending_i or tx_busy_i is 1.
- R9: After tx_pending_i and tx_busy_i both fall, the enable stays 1 until turn_bits_i bit_tick_i pulses have been seen with the transmitter idle. It falls in the cycle after the last such pulse. A pulse that coincides with activity does not count.
- R10: With turn_bits_i = 0, the enable falls in the same cycle that activity ends.
- R11: Activity during the hold period abandons the count. The enable stays 1, and a full turn_bits_i count starts again after the next idle.
- R12: With auto_dir_i=1 and dir_pin_i=0, rts_o follows the enable and dtr_o equals dtr_manual_i. The rts_manual_i, flow_en_i and rts_flow_i inputs are ignored.
- R13: With auto_dir_i=1 and dir_pin_i=1, dtr_o follows the enable. rts_o takes its normal value: rts_flow_i when flow_en_i=1, otherwise rts_manual_i.
- R14: With auto_dir_i=0, rts_o takes its normal value as in R13 and dtr_o equals dtr_manual_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| filt_en_i | input | 1 | Enables 9-bit address filtering |
| node_addr_i | input | DATA_W | This node's address |
| rx_valid_i | input | 1 | Received character strobe |
| rx_char_i | input | DATA_W+1 | Received character; top bit 1 = address |
| rx_valid_o | output | 1 | Filtered receive strobe |
| rx_data_o | output | DATA_W | Filtered receive byte |
| tx_pending_i | input | 1 | Transmit data waiting |
| tx_busy_i | input | 1 | Transmit shifter active, through the stop bit |
| bit_tick_i | input | 1 | One pulse per bit period |
| turn_bits_i | input | CNT_W | Post-transmit hold in bit periods |
| auto_dir_i | input | 1 | Enables automatic direction control |
| dir_pin_i | input | 1 | Direction pin: 0 = rts_o, 1 = dtr_o |
| rts_manual_i | input | 1 | Software-written RTS level |
| flow_en_i | input | 1 | Hardware flow control owns RTS |
| rts_flow_i | input | 1 | RTS level from flow control |
| dtr_manual_i | input | 1 | Software-written DTR level |
| rts_o | output | 1 | RTS pin level |
| dtr_o | output | 1 | DTR pin level |

## Verification
A stuck or wrongly updated selected-state bit shows up on the first data byte after the faulty event. That byte is either forwarded when it should be dropped or dropped when it should pass, one cycle after its strobe. An off-by-one or a missed reload in the hold counter moves the falling edge of the driver enable by one bit tick. That error is seen on the first idle period after a transmission. A routing error in the pin selection appears at once on rts_o or dtr_o, in the same cycle as the control change.

// File: rtl/rs485_pkg.sv
package rs485_pkg;
  typedef enum logic {
    DIR_ON_RTS = 1'b0,
    DIR_ON_DTR = 1'b1
  } dir_pin_e;
endpackage

// File: rtl/rs485_addr_filter.sv
module rs485_addr_filter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              filt_en_i,
  input  logic [DATA_W-1:0] node_addr_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W:0]   rx_char_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int unsigned FlagBit = DATA_W;

  logic selected_q, valid_q;
  logic [DATA_W-1:0] data_q;
  logic is_addr, hit, accept;

  assign is_addr = rx_char_i[FlagBit];
  assign hit     = rx_char_i[DATA_W-1:0] == node_addr_i;
  assign accept  = rx_valid_i && (!filt_en_i || (is_addr ? hit : selected_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      selected_q <= 1'b0;
      valid_q    <= 1'b0;
      data_q     <= '0;
    end else begin
      valid_q <= accept;
      if (accept) data_q <= rx_char_i[DATA_W-1:0];
      if (!filt_en_i)                 selected_q <= 1'b0;
      else if (rx_valid_i && is_addr) selected_q <= hit;
    end
  end

  assign rx_valid_o = valid_q;
  assign rx_data_o  = data_q;
endmodule

// File: rtl/rs485_turnaround.sv
module rs485_turnaround #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_pending_i,
  input  logic             tx_busy_i,
  input  logic             bit_tick_i,
  input  logic [CNT_W-1:0] turn_bits_i,
  output logic             drive_o
);
  logic             active;
  logic [CNT_W-1:0] hold_q;

  assign active = tx_pending_i | tx_busy_i;

  // reload while active so new data abandons any running count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            hold_q <= '0;
    else if (active)                        hold_q <= turn_bits_i;
    else if (bit_tick_i && hold_q != '0)    hold_q <= hold_q - 1'b1;
  end

  assign drive_o = active | (hold_q != '0);
endmodule

// File: rtl/rs485_pin_mux.sv
module rs485_pin_mux
  import rs485_pkg::*;
(
  input  logic drive_i,
  input  logic auto_dir_i,
  input  logic dir_pin_i,
  input  logic rts_manual_i,
  input  logic flow_en_i,
  input  logic rts_flow_i,
  input  logic dtr_manual_i,
  output logic rts_o,
  output logic dtr_o
);
  dir_pin_e pin;
  logic     rts_base;

  assign pin      = dir_pin_e'(dir_pin_i);
  assign rts_base = flow_en_i ? rts_flow_i : rts_manual_i;

  always_comb begin
    rts_o = rts_base;
    dtr_o = dtr_manual_i;
    if (auto_dir_i) begin
      unique case (pin)
        DIR_ON_RTS: rts_o = drive_i;
        DIR_ON_DTR: dtr_o = drive_i;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/rs485_node_ctl.sv
module rs485_node_ctl #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              filt_en_i,
  input  logic [DATA_W-1:0] node_addr_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W:0]   rx_char_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              tx_pending_i,
  input  logic              tx_busy_i,
  input  logic              bit_tick_i,
  input  logic [CNT_W-1:0]  turn_bits_i,
  input  logic              auto_dir_i,
  input  logic              dir_pin_i,
  input  logic              rts_manual_i,
  input  logic              flow_en_i,
  input  logic              rts_flow_i,
  input  logic              dtr_manual_i,
  output logic              rts_o,
  output logic              dtr_o
);
  logic drive;

  rs485_addr_filter #(.DATA_W(DATA_W)) u_filter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .filt_en_i   (filt_en_i),
    .node_addr_i (node_addr_i),
    .rx_valid_i  (rx_valid_i),
    .rx_char_i   (rx_char_i),
    .rx_valid_o  (rx_valid_o),
    .rx_data_o   (rx_data_o)
  );

  rs485_turnaround #(.CNT_W(CNT_W)) u_turn (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tx_pending_i (tx_pending_i),
    .tx_busy_i    (tx_busy_i),
    .bit_tick_i   (bit_tick_i),
    .turn_bits_i  (turn_bits_i),
    .drive_o      (drive)
  );

  rs485_pin_mux u_mux (
    .drive_i      (drive),
    .auto_dir_i   (auto_dir_i),
    .dir_pin_i    (dir_pin_i),
    .rts_manual_i (rts_manual_i),
    .flow_en_i    (flow_en_i),
    .rts_flow_i   (rts_flow_i),
    .dtr_manual_i (dtr_manual_i),
    .rts_o        (rts_o),
    .dtr_o        (dtr_o)
  );
endmodule

// File: rtl/rs485_node_chk.sv
module rs485_node_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              filt_en_i,
  input logic [DATA_W-1:0] node_addr_i,
  input logic              rx_valid_i,
  input logic [DATA_W:0]   rx_char_i,
  input logic              rx_valid_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              tx_pending_i,
  input logic              tx_busy_i,
  input logic              bit_tick_i,
  input logic [CNT_W-1:0]  turn_bits_i,
  input logic              auto_dir_i,
  input logic              dir_pin_i,
  input logic              rts_manual_i,
  input logic              flow_en_i,
  input logic              rts_flow_i,
  input logic              dtr_manual_i,
  input logic              rts_o,
  input logic              dtr_o
);
  logic act, on_rts;
  assign act    = tx_pending_i | tx_busy_i;
  assign on_rts = auto_dir_i && !dir_pin_i;

  // R2
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!filt_en_i && rx_valid_i) |=> (rx_valid_o && rx_data_o == $past(rx_char_i[DATA_W-1:0])));

  // R3
  addr_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_en_i && rx_valid_i && rx_char_i[DATA_W] && rx_char_i[DATA_W-1:0] == node_addr_i)
    |=> rx_valid_o);

  // R5
  addr_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_en_i && rx_valid_i && rx_char_i[DATA_W] && rx_char_i[DATA_W-1:0] != node_addr_i)
    |=> !rx_valid_o);

  // R8
  early_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_rts && act) |-> rts_o);

  // R9
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_rts && $past(on_rts) && $past(rts_o) && !$past(act) && !$past(bit_tick_i)) |-> rts_o);

  // R10
  zero_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_rts && !act && $past(act) && $past(turn_bits_i) == '0) |-> !rts_o);
endmodule

bind rs485_node_ctl rs485_node_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_rs485_node_ctl.sv
`timescale 1ns/1ps
module tb_rs485_node_ctl;
  localparam int DW = 8;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic filt_en = 0, rx_valid = 0, rx_valid_o;
  logic [DW-1:0] node_addr = 8'h5A, rx_data_o;
  logic [DW:0] rx_char = '0;
  logic pend = 0, busy = 0, tick = 0;
  logic [CW-1:0] turn = '0;
  logic auto_dir = 0, dir_pin = 0, rts_man = 0, flow_en = 0, rts_flow = 0, dtr_man = 0;
  logic rts_o, dtr_o;

  int total = 0, bad = 0;
  logic sel_m = 0;

  always #2 clk = ~clk;

  rs485_node_ctl #(.DATA_W(DW), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .filt_en_i(filt_en), .node_addr_i(node_addr),
    .rx_valid_i(rx_valid), .rx_char_i(rx_char), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
    .tx_pending_i(pend), .tx_busy_i(busy), .bit_tick_i(tick), .turn_bits_i(turn),
    .auto_dir_i(auto_dir), .dir_pin_i(dir_pin), .rts_manual_i(rts_man), .flow_en_i(flow_en),
    .rts_flow_i(rts_flow), .dtr_manual_i(dtr_man), .rts_o(rts_o), .dtr_o(dtr_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // send one char, check the filtered result one cycle later against the model
  task automatic send(logic [DW:0] c, string req);
    logic exp_v;
    exp_v = !filt_en || (c[DW] ? (c[DW-1:0] == node_addr) : sel_m);
    if (!filt_en) sel_m = 0;
    else if (c[DW]) sel_m = (c[DW-1:0] == node_addr);
    @(negedge clk); rx_valid = 1; rx_char = c;
    @(negedge clk); rx_valid = 0;
    #1;
    check(req, {31'd0, rx_valid_o}, {31'd0, exp_v});
    if (exp_v) check(req, {24'd0, rx_data_o}, {24'd0, c[DW-1:0]});
  endtask

  task automatic idle_cycle();
    @(negedge clk); #1;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1 valid", {31'd0, rx_valid_o}, 32'd0);
    check("R1 rts", {31'd0, rts_o}, 32'd0);
    filt_en = 1;
    send({1'b0, 8'h33}, "R1 data before addr");

    // R2 pass-through sweep
    filt_en = 0;
    for (int c = 0; c < 512; c += 3) send(c[DW:0], "R2");

    // R3 R4 R5 R6 full sweep with periodic selects
    filt_en = 1;
    for (int c = 0; c < 512; c++) begin
      if (c % 37 == 0) send({1'b1, node_addr}, "R3");
      send(c[DW:0], c[DW] ? ((c[DW-1:0] == node_addr) ? "R3" : "R5") : (sel_m ? "R6" : "R4"));
    end
    node_addr = 8'h00;
    send({1'b1, 8'h00}, "R3 addr0");
    send({1'b0, 8'hFF}, "R6");
    send({1'b1, 8'h01}, "R5");
    send({1'b0, 8'hFF}, "R4");
    node_addr = 8'h5A;

    // R7 disable clears selection
    send({1'b1, 8'h5A}, "R7 select");
    filt_en = 0;
    send({1'b0, 8'h11}, "R7 off");
    filt_en = 1;
    send({1'b0, 8'h22}, "R7 dropped");
    check("R7 model", {31'd0, sel_m}, 32'd0);

    // turnaround sweep on RTS
    auto_dir = 1; dir_pin = 0;
    for (int n = 0; n < 7; n++) begin
      turn = n[CW-1:0];
      @(negedge clk); pend = 1; #1;
      check("R8 pending", {31'd0, rts_o}, 32'd1);
      @(negedge clk); pend = 0; busy = 1;
      pulse_tick();                       // tick during activity: no effect
      @(negedge clk); busy = 0; #1;
      if (n == 0) check("R10", {31'd0, rts_o}, 32'd0);
      else check("R9 after idle", {31'd0, rts_o}, 32'd1);
      for (int k = 1; k <= n; k++) begin
        idle_cycle();
        check("R9 no tick", {31'd0, rts_o}, 32'd1);
        pulse_tick();
        check("R9 count", {31'd0, rts_o}, {31'd0, (k < n)});
        if (n >= 3 && k == 1) begin
          @(negedge clk); pend = 1; #1;
          check("R11 active", {31'd0, rts_o}, 32'd1);
          @(negedge clk); pend = 0; #1;
          check("R11 restart", {31'd0, rts_o}, 32'd1);
          for (int j = 1; j <= n; j++) begin
            pulse_tick();
            check("R11 count", {31'd0, rts_o}, {31'd0, (j < n)});
          end
          break;
        end
      end
    end

    // pin routing sweep, turn=0 so enable equals activity
    turn = '0;
    for (int v = 0; v < 128; v++) begin
      logic en_x, r_exp, d_exp;
      @(negedge clk);
      auto_dir = v[0]; dir_pin = v[1]; rts_man = v[2]; flow_en = v[3];
      rts_flow = v[4]; dtr_man = v[5]; pend = v[6];
      #1;
      en_x  = v[6];
      r_exp = (v[0] && !v[1]) ? en_x : (v[3] ? v[4] : v[2]);
      d_exp = (v[0] && v[1]) ? en_x : v[5];
      if (!v[0]) begin
        check("R14 rts", {31'd0, rts_o}, {31'd0, r_exp});
        check("R14 dtr", {31'd0, dtr_o}, {31'd0, d_exp});
      end else if (!v[1]) begin
        check("R12 rts", {31'd0, rts_o}, {31'd0, r_exp});
        check("R12 dtr", {31'd0, dtr_o}, {31'd0, d_exp});
      end else begin
        check("R13 rts", {31'd0, rts_o}, {31'd0, r_exp});
        check("R13 dtr", {31'd0, dtr_o}, {31'd0, d_exp});
      end
    end
    @(negedge clk); pend = 0;

    // R13 hold on DTR
    auto_dir = 1; dir_pin = 1; turn = 8'd2;
    @(negedge clk); busy = 1;
    @(negedge clk); busy = 0; #1;
    check("R13 hold", {31'd0, dtr_o}, 32'd1);
    pulse_tick();
    pulse_tick();
    check("R13 release", {31'd0, dtr_o}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule